// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that is programmed through a single 12-bit control word. Software picks a reference-clock divider and one of four timeout lengths, then turns on counting, the interrupt and the system reset. A restart command reloads the counter. While software keeps issuing restarts in time, nothing happens.

When the count runs out the first time, the block sets a sticky interrupt flag. If interrupts are enabled, it drives its interrupt line. It then reloads a fixed grace count at the same prescale and keeps counting. If the count runs out again while the interrupt flag is still set and resets are enabled, the block sets a sticky reset flag and pulses the system reset output for one clock cycle.

The reset flag sits on a separate power-on reset. The core reset that the watchdog itself triggers therefore leaves the flag in place, and software can read it afterwards to learn why the chip restarted. One down-counter serves both the interval phase and the grace phase.

Top module: `wdt_top`

## Requirements
- R1: After both resets the control word reads 0x400 (clock select 1 in bits 11:10, every other bit 0), and `irq` and `sysRst` are low.
- R2: Clock select (bits 11:10) values 0, 1, 2 and 3 give one counter tick every 1, 256, 2048 and 65536 clock cycles.
- R3: With interval select `s` (bits 5:4), the first expiry comes 2^(BASE_SHIFT+2*s) ticks after a restart.
- R4: Writing 1 to bit 0 (restart) reloads the counter from the interval select written in the same word and restarts the prescaler. Bit 0 always reads 0.
- R5: Changing enable (bit 7) without a restart pauses or resumes the count and keeps the remaining value.
- R6: The first expiry with enable set and the interrupt flag (bit 3) clear sets that flag. `irq` is high exactly when the interrupt flag and interrupt enable (bit 6) are both set.
- R7: After the first expiry the counter reloads GRACE_TICKS ticks. When those run out with the interrupt flag set and reset enable (bit 1) set, the reset flag (bit 2) is set and `sysRst` is high for exactly one cycle.
- R8: Writing 1 to bit 3 or bit 2 clears that flag. Writing 0 leaves it unchanged.
- R9: While enable is clear, no expiry occurs and the flags do not change.
- R10: `rstN` alone does not clear the reset flag. Only `porN` clears it.
- R11: A second expiry with reset enable clear neither sets the reset flag nor pulses `sysRst`.
- R12: Freeze enable (bit 9) is stored and read back, and it has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low core reset; clears everything except the reset flag |
| porN | input | 1 | Active-low power-on reset; clears the reset flag |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 12 | Control word to write |
| rdData | output | 12 | Current control word; bit 0 and bit 8 read 0 |
| irq | output | 1 | Interrupt, level |
| sysRst | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is the second expiry. The bench must let the interval run out, leave the interrupt flag set and then wait through the full grace count. Only then do the reset pulse and the reset flag appear. The bench builds the block with a small BASE_SHIFT and divide-by-1 so the interval lasts a few ticks. It then counts exactly through the 1024-tick grace window and checks `sysRst` on the cycle before the pulse, during it and after it. It runs this sequence once with reset enable set and once with it clear. A core-only reset then checks that the reset flag survives.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTL_W    = 12;
  localparam int B_RESTART = 0;
  localparam int B_RSTEN  = 1;
  localparam int B_RSTFLG = 2;
  localparam int B_INTFLG = 3;
  localparam int B_INTEN  = 6;
  localparam int B_EN     = 7;
  localparam int B_FRZ    = 9;

  typedef struct packed {
    logic       run;
    logic       loadIntv;
    logic       loadGrace;
    logic [1:0] divSel;
    logic [1:0] intvSel;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_SHIFT  = 14,
  parameter int GRACE_TICKS = 1024,
  parameter int DIV0 = 1,
  parameter int DIV1 = 256,
  parameter int DIV2 = 2048,
  parameter int DIV3 = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t stb,
  output logic       expire
);
  localparam int DIVS[4] = '{DIV0, DIV1, DIV2, DIV3};
  localparam int MAXDIV  = (DIV3 > DIV2) ? ((DIV3 > DIV1) ? DIV3 : DIV1) : DIV2;
  localparam int PRE_W   = $clog2(MAXDIV > DIV0 ? MAXDIV : DIV0) + 1;
  localparam int LONGEST = (1 << (BASE_SHIFT + 6)) > GRACE_TICKS ?
                           (1 << (BASE_SHIFT + 6)) : GRACE_TICKS;
  localparam int CNT_W   = $clog2(LONGEST) + 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preTerm;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] intvLoad;
  logic [PRE_W-1:0] termTab[4];
  logic             tick;

  // one terminal count per clock select
  for (genvar g = 0; g < 4; g++) begin : g_term
    assign termTab[g] = PRE_W'(DIVS[g] - 1);
  end

  assign preTerm  = termTab[stb.divSel];
  assign tick     = stb.run && (preCnt == preTerm);
  assign expire   = tick && (cnt == CNT_W'(1));
  assign intvLoad = CNT_W'(1) << (BASE_SHIFT + 2 * int'(stb.intvSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= CNT_W'(1) << BASE_SHIFT;
    end else if (stb.loadIntv) begin
      preCnt <= '0;
      cnt    <= intvLoad;
    end else begin
      if (stb.run) preCnt <= tick ? '0 : preCnt + 1'b1;
      if (stb.loadGrace)                    cnt <= CNT_W'(GRACE_TICKS);
      else if (tick && cnt > CNT_W'(1))     cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  input  logic             expire,
  output wdtStrobe_t       stb,
  output logic [CTL_W-1:0] rdData,
  output logic             irq,
  output logic             sysRst
);
  logic [1:0] clkSel, intvSel;
  logic       freezeEn, enable, intEn, intFlag, rstEn, rstFlag;
  logic       expHit, setInt, fireRst;

  assign expHit  = expire && !stb.loadIntv;
  assign setInt  = expHit && !intFlag;
  assign fireRst = expHit && intFlag && rstEn;

  assign stb.run       = enable;
  assign stb.loadIntv  = wrEn && wrData[B_RESTART];
  assign stb.loadGrace = expHit;
  assign stb.divSel    = clkSel;
  assign stb.intvSel   = wrData[5:4];

  assign irq    = intFlag && intEn;
  assign rdData = {clkSel, freezeEn, 1'b0, enable, intEn, intvSel,
                   intFlag, rstFlag, rstEn, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel   <= 2'd1;
      freezeEn <= 1'b0;
      enable   <= 1'b0;
      intEn    <= 1'b0;
      intvSel  <= 2'd0;
      rstEn    <= 1'b0;
      intFlag  <= 1'b0;
      sysRst   <= 1'b0;
    end else begin
      if (wrEn) begin
        clkSel   <= wrData[11:10];
        freezeEn <= wrData[B_FRZ];
        enable   <= wrData[B_EN];
        intEn    <= wrData[B_INTEN];
        intvSel  <= wrData[5:4];
        rstEn    <= wrData[B_RSTEN];
      end
      if (setInt)                              intFlag <= 1'b1;
      else if (wrEn && wrData[B_INTFLG])       intFlag <= 1'b0;
      sysRst <= fireRst;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                             rstFlag <= 1'b0;
    else if (fireRst)                      rstFlag <= 1'b1;
    else if (wrEn && wrData[B_RSTFLG])     rstFlag <= 1'b0;
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int BASE_SHIFT  = 14,
  parameter int GRACE_TICKS = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        porN,
  input  logic        wrEn,
  input  logic [11:0] wrData,
  output logic [11:0] rdData,
  output logic        irq,
  output logic        sysRst
);
  wdtStrobe_t stb;
  logic       expire;

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .porN(porN), .wrEn(wrEn), .wrData(wrData),
    .expire(expire), .stb(stb), .rdData(rdData), .irq(irq), .sysRst(sysRst)
  );

  wdt_datapath #(.BASE_SHIFT(BASE_SHIFT), .GRACE_TICKS(GRACE_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .expire(expire)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [11:0] rdData,
  input logic        irq,
  input logic        sysRst
);
  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |=> !sysRst);
  // R7
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |-> rdData[2]);
  // R11
  rst_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |-> $past(rdData[1]));
  // R6
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rdData[3]);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[7] && !wrEn) |=> !$rose(rdData[3]));
endmodule

bind wdt_top wdt_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdData(rdData), .irq(irq), .sysRst(sysRst)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        porN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrData = '0;
  logic [11:0] rdData;
  logic        irq, sysRst;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wdt_top #(.BASE_SHIFT(2), .GRACE_TICKS(1024)) u0 (
    .clk(clk), .rstN(rstN), .porN(porN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irq(irq), .sysRst(sysRst)
  );

  // {clkSel, intvSel, intEn, cycles to first expiry}
  localparam logic [35:0] VEC[6] = '{
    {2'd0, 2'd0, 1'b1, 31'd4},
    {2'd0, 2'd1, 1'b0, 31'd16},
    {2'd0, 2'd2, 1'b1, 31'd64},
    {2'd0, 2'd3, 1'b0, 31'd256},
    {2'd1, 2'd0, 1'b1, 31'd1024},
    {2'd2, 2'd0, 1'b0, 31'd8192}
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic wr(input logic [11:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitN(3);
    rstN = 1'b1; porN = 1'b1;
    waitN(1);
    chk("R1 reset word", rdData, 12'h400);
    chk("R1 reset outputs", {10'd0, irq, sysRst}, 12'h000);

    // R2 R3 R6: table of prescale/interval settings
    for (int i = 0; i < 6; i++) begin
      logic [1:0] cs = VEC[i][35:34];
      logic [1:0] is = VEC[i][33:32];
      logic       ie = VEC[i][31];
      int         n  = int'(VEC[i][30:0]);
      wr(12'h00C);
      wr({cs, 2'b00, 1'b1, ie, is, 4'b1001});
      waitN(n - 1);
      chk("R2 R3 no expiry before timeout", {11'd0, rdData[3]}, 12'd0);
      waitN(1);
      chk("R6 flag at timeout", {11'd0, rdData[3]}, 12'd1);
      chk("R6 irq follows enable", {11'd0, irq}, {11'd0, ie});
    end

    // R8: interrupt flag write-one-to-clear while stopped
    wr(12'h000);
    chk("R8 write 0 keeps flag", {11'd0, rdData[3]}, 12'd1);
    wr(12'h008);
    chk("R8 write 1 clears flag", rdData, 12'h000);

    // R4 R5: pause and resume without reload
    wr(12'h081);
    chk("R4 restart reads 0", {11'd0, rdData[0]}, 12'd0);
    wr(12'h000);
    waitN(20);
    chk("R5 paused no expiry", {11'd0, rdData[3]}, 12'd0);
    wr(12'h080);
    waitN(1);
    chk("R5 resumed kept count", {11'd0, rdData[3]}, 12'd0);
    waitN(1);
    chk("R5 resumed expiry", {11'd0, rdData[3]}, 12'd1);

    // R9: enable clear, restart issued, no expiry
    wr(12'h00D);
    waitN(300);
    chk("R9 disabled no flag", {10'd0, rdData[3], irq}, 12'd0);

    // R11: second expiry with reset disabled
    wr(12'h0CD);
    waitN(4);
    chk("R11 first expiry irq", {11'd0, irq}, 12'd1);
    waitN(1024);
    chk("R11 no reset or flag", {10'd0, sysRst, rdData[2]}, 12'd0);
    waitN(5);
    chk("R11 still no reset", {11'd0, sysRst}, 12'd0);

    // R7: full two-stage sequence with reset enabled
    wr(12'h00C);
    wr(12'h0CB);
    waitN(3);
    chk("R6 irq low before expiry", {11'd0, irq}, 12'd0);
    waitN(1);
    chk("R6 irq high at expiry", {11'd0, irq}, 12'd1);
    waitN(1023);
    chk("R7 no reset before grace end", {11'd0, sysRst}, 12'd0);
    waitN(1);
    chk("R7 reset pulse and flag", {10'd0, sysRst, rdData[2]}, 12'd3);
    waitN(1);
    chk("R7 reset one cycle", {11'd0, sysRst}, 12'd0);

    // R10: core reset keeps reset flag
    wr(12'h008);
    rstN = 1'b0;
    waitN(2);
    rstN = 1'b1;
    waitN(1);
    chk("R10 flag survives core reset", rdData, 12'h404);
    wr(12'h400);
    chk("R8 write 0 keeps reset flag", rdData, 12'h404);
    wr(12'h404);
    chk("R8 write 1 clears reset flag", rdData, 12'h400);
    porN = 1'b0;
    waitN(1);
    porN = 1'b1;
    chk("R10 power-on clears flag", {11'd0, rdData[2]}, 12'd0);

    // R12: freeze bit stored, counting unaffected
    wr(12'h281);
    chk("R12 freeze reads back", rdData, 12'h280);
    waitN(3);
    chk("R12 no early expiry", {11'd0, rdData[3]}, 12'd0);
    waitN(1);
    chk("R12 expiry with freeze set", {11'd0, rdData[3]}, 12'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule